// File: doc/BRIEF.md
# Nonvolatile Store/Recall Sequencer

This block decides when the contents of a volatile array are copied into their nonvolatile shadow (a store) and when the shadow is copied back (a recall). It tracks whether any write has completed since the last transfer. It accepts store requests from a supply-fail comparator and from a shared, active-low open-drain request line. Before a store it grants a grace window, and it holds the shared line low while the store runs. When supply returns it runs an automatic recall. Toward the memory bus it drives separate read and write inhibits.

The shared line is modelled as a drive enable plus a sampled level. The board resolves the wired value: the line is low when any device drives it, and high otherwise. The sampled level passes through a synchronizer. A low level is only taken as a request once it has lasted a minimum number of synchronized cycles. All durations are parameters counted in clock cycles. The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a plain control or status level, except the two done outputs, which are single-cycle pulses.

Top module: `nvs_seq`

## Requirements
- R1: Out of reset the supply is treated as absent. Both inhibits are high and the line drive is off until `pwr_ok_i` is seen high.
- R2: When `pwr_ok_i` is seen high in the power-low state, a recall runs for RECALL_CYC cycles. `recall_done_o` pulses in the last of those cycles, and both inhibits drop in the next cycle.
- R3: A low on the synchronized request line counts as an external request only if it lasts at least MIN_PULSE consecutive cycles. Shorter lows have no effect.
- R4: An external request while no write has completed since the last store or recall is ignored: no drive, no `store_done_o`, and the block stays idle.
- R5: An accepted request opens a grace window. Reads stay allowed and writes are inhibited. For an external request, the accepting idle cycle plus GRACE_CYC grace cycles show `wr_inhibit_o` high with `rd_inhibit_o` low.
- R6: A store drives the line for exactly STORE_CYC cycles with both inhibits high. `store_done_o` pulses in the last store cycle, and the dirty flag is cleared.
- R7: After an externally requested store, the block stays inhibited until the synchronized line is high. It then waits RESTORE_CYC cycles before returning to idle.
- R8: On supply loss with the dirty flag set, the block drives the line during the grace window and then stores, for GRACE_CYC + STORE_CYC drive cycles, and ends in the power-low state. On supply loss when clean, it goes to power-low with no drive.
- R9: If, at the end of a supply-loss grace window, the synchronized line is still high (overpowered), the block stops driving, abandons the store and goes to power-low.
- R10: A write completion reported during a store, recall or restore does not set the dirty flag.
- R11: A supply loss and an external request on the same cycle cause one store. Requests that arrive during a store are ignored.
- R12: If supply drops during a recall, the recall is abandoned without `recall_done_o`. A full recall runs again when supply returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_ok_i | input | 1 | Supply-above-threshold indication from the comparator |
| line_i | input | 1 | Sampled level of the shared open-drain request/busy line (low = asserted) |
| wr_done_i | input | 1 | One-cycle pulse for each completed array write |
| busy_drive_o | output | 1 | Drive enable that pulls the shared line low |
| rd_inhibit_o | output | 1 | Blocks array reads |
| wr_inhibit_o | output | 1 | Blocks new array writes |
| store_done_o | output | 1 | Pulse in the last cycle of a store |
| recall_done_o | output | 1 | Pulse in the last cycle of a recall |

## Verification
The external request width is swept from one cycle up past MIN_PULSE with the dirty flag set. This separates rejected glitches from accepted requests at the exact threshold. Clean and dirty requests, and requests from supply loss and from the line, are tried separately. Together they tell the dirty gate apart from the source routing. An overpowered line (held high) separates an abandoned supply-loss store from a completed one. A line held low past the store end, and writes reported mid-store, show the release wait and the dirty-flag masking. A supply dip inside a recall, and coincident or overlapping requests, cover the restart and merge rules.

// File: rtl/nvs_pkg.sv
package nvs_pkg;
  typedef enum logic [2:0] {
    ST_PWRLOW,
    ST_RECALL,
    ST_IDLE,
    ST_GRACE,
    ST_STORE,
    ST_WAITHI,
    ST_RESTORE
  } seq_state_e;
endpackage

// File: rtl/nvs_req_filter.sv
// Synchronizes the shared line and qualifies a low level by minimum width.
module nvs_req_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_hi_o,
  output logic req_o
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
  end

  assign line_hi_o = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         low_cnt <= '0;
    else if (line_hi_o)                 low_cnt <= '0;
    else if (low_cnt != CW'(MIN_PULSE)) low_cnt <= low_cnt + 1'b1;
  end

  assign req_o = (low_cnt == CW'(MIN_PULSE));
endmodule

// File: rtl/nvs_timer.sv
// Down-counter shared by all timed phases.
module nvs_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load_i)       cnt_q <= val_i;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/nvs_dirty.sv
// Remembers whether any write completed since the last transfer.
module nvs_dirty (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic dirty_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dirty_o <= 1'b0;
    else if (clr_i) dirty_o <= 1'b0;
    else if (set_i) dirty_o <= 1'b1;
  end
endmodule

// File: rtl/nvs_seq.sv
module nvs_seq #(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_PULSE   = 4,
  parameter int GRACE_CYC   = 100,
  parameter int STORE_CYC   = 1000000,
  parameter int RESTORE_CYC = 70,
  parameter int RECALL_CYC  = 55000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_ok_i,
  input  logic line_i,
  input  logic wr_done_i,
  output logic busy_drive_o,
  output logic rd_inhibit_o,
  output logic wr_inhibit_o,
  output logic store_done_o,
  output logic recall_done_o
);
  import nvs_pkg::*;

  localparam int MAX_AB = (GRACE_CYC > STORE_CYC) ? GRACE_CYC : STORE_CYC;
  localparam int MAX_CD = (RESTORE_CYC > RECALL_CYC) ? RESTORE_CYC : RECALL_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TW     = $clog2(MAXC + 1);

  seq_state_e state_q, state_d;
  logic       src_pf_q, src_pf_d;
  logic       t_load, t_zero;
  logic [TW-1:0] t_val;
  logic       line_hi, ext_req, dirty, dirty_set;

  nvs_req_filter #(.SYNC_STAGES(SYNC_STAGES), .MIN_PULSE(MIN_PULSE)) u_filt (
    .clk(clk), .rst_n(rst_n), .line_i(line_i),
    .line_hi_o(line_hi), .req_o(ext_req)
  );

  nvs_timer #(.W(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load_i(t_load), .val_i(t_val), .zero_o(t_zero)
  );

  assign dirty_set = wr_done_i && (state_q == ST_IDLE || state_q == ST_GRACE);

  nvs_dirty u_dirty (
    .clk(clk), .rst_n(rst_n), .set_i(dirty_set),
    .clr_i(store_done_o || recall_done_o), .dirty_o(dirty)
  );

  always_comb begin
    state_d  = state_q;
    src_pf_d = src_pf_q;
    t_load   = 1'b0;
    t_val    = '0;
    unique case (state_q)
      ST_PWRLOW: if (pwr_ok_i) begin
        state_d = ST_RECALL;
        t_load  = 1'b1;
        t_val   = TW'(RECALL_CYC - 1);
      end
      ST_RECALL: begin
        if (!pwr_ok_i)   state_d = ST_PWRLOW;
        else if (t_zero) state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!pwr_ok_i) begin
          if (dirty) begin
            state_d  = ST_GRACE;
            src_pf_d = 1'b1;
            t_load   = 1'b1;
            t_val    = TW'(GRACE_CYC - 1);
          end else begin
            state_d = ST_PWRLOW;
          end
        end else if (ext_req && dirty) begin
          state_d  = ST_GRACE;
          src_pf_d = 1'b0;
          t_load   = 1'b1;
          t_val    = TW'(GRACE_CYC - 1);
        end
      end
      ST_GRACE: if (t_zero) begin
        if (src_pf_q && line_hi) begin
          state_d = ST_PWRLOW;
        end else begin
          state_d = ST_STORE;
          t_load  = 1'b1;
          t_val   = TW'(STORE_CYC - 1);
        end
      end
      ST_STORE: if (t_zero) state_d = src_pf_q ? ST_PWRLOW : ST_WAITHI;
      ST_WAITHI: begin
        if (!pwr_ok_i) state_d = ST_PWRLOW;
        else if (line_hi) begin
          state_d = ST_RESTORE;
          t_load  = 1'b1;
          t_val   = TW'(RESTORE_CYC - 1);
        end
      end
      ST_RESTORE: begin
        if (!pwr_ok_i)   state_d = ST_PWRLOW;
        else if (t_zero) state_d = ST_IDLE;
      end
      default: state_d = ST_PWRLOW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_PWRLOW;
      src_pf_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      src_pf_q <= src_pf_d;
    end
  end

  assign busy_drive_o  = (state_q == ST_STORE) || (state_q == ST_GRACE && src_pf_q);
  assign rd_inhibit_o  = !(state_q == ST_IDLE || state_q == ST_GRACE);
  assign wr_inhibit_o  = (state_q != ST_IDLE) || ext_req;
  assign store_done_o  = (state_q == ST_STORE) && t_zero;
  assign recall_done_o = (state_q == ST_RECALL) && t_zero && pwr_ok_i;
endmodule

// File: rtl/nvs_seq_chk.sv
module nvs_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic busy_drive_o,
  input logic rd_inhibit_o,
  input logic wr_inhibit_o,
  input logic store_done_o,
  input logic recall_done_o
);
  assert_busy_blocks_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy_drive_o |-> wr_inhibit_o);
  assert_store_done_while_driving_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_done_o |-> busy_drive_o);
  assert_store_done_releases_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
    store_done_o |=> !busy_drive_o);
  assert_recall_done_frees_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    recall_done_o |=> !rd_inhibit_o);
  assert_single_done_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_done_o, recall_done_o}));
  assert_read_block_implies_write_block_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_inhibit_o |-> wr_inhibit_o);
endmodule

bind nvs_seq nvs_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy_drive_o(busy_drive_o),
  .rd_inhibit_o(rd_inhibit_o), .wr_inhibit_o(wr_inhibit_o),
  .store_done_o(store_done_o), .recall_done_o(recall_done_o)
);

// File: tb/nvs_seq_tb.sv
`timescale 1ns/1ps
module nvs_seq_tb;
  localparam int SYNC = 2, MINP = 3, GRACE = 6, STORE = 20, RESTORE = 4, RECALL = 12;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b0, wr_done = 1'b0;
  logic ext_pull = 1'b0, hold_high = 1'b0;
  logic line, busy, rd_inh, wr_inh, sdone, rdone;
  int checks = 0, errors = 0, sd_cnt = 0, rc_cnt = 0, bc = 0;

  always #5 clk = ~clk;

  assign line = hold_high ? 1'b1 : ~(busy | ext_pull);

  nvs_seq #(.SYNC_STAGES(SYNC), .MIN_PULSE(MINP), .GRACE_CYC(GRACE),
            .STORE_CYC(STORE), .RESTORE_CYC(RESTORE), .RECALL_CYC(RECALL)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_ok_i(pwr_ok), .line_i(line), .wr_done_i(wr_done),
    .busy_drive_o(busy), .rd_inhibit_o(rd_inh), .wr_inhibit_o(wr_inh),
    .store_done_o(sdone), .recall_done_o(rdone)
  );

  task automatic tick();
    @(negedge clk);
    if (sdone) sd_cnt++;
    if (rdone) rc_cnt++;
    if (busy)  bc++;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic clr();
    sd_cnt = 0; rc_cnt = 0; bc = 0;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write1();
    wr_done = 1'b1; tick(); wr_done = 1'b0; tick();
  endtask

  task automatic ext_pulse(input int w);
    ext_pull = 1'b1; run(w); ext_pull = 1'b0;
  endtask

  task automatic power_up();
    pwr_ok = 1'b1; run(RECALL + 6);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    run(3); rst_n = 1'b1; run(5);
    // R1: supply absent after reset
    chk("R1 rd_inh", rd_inh, 1); chk("R1 wr_inh", wr_inh, 1); chk("R1 busy", busy, 0);

    // R2: recall duration and release
    clr(); pwr_ok = 1'b1; n = 0;
    for (int i = 1; i <= 50; i++) begin tick(); if (rdone) begin n = i; break; end end
    chk("R2 recall cycles", n, RECALL);
    tick();
    chk("R2 rd_inh released", rd_inh, 0); chk("R2 wr_inh released", wr_inh, 0);

    // R4: clean request ignored
    clr(); ext_pulse(6); run(60);
    chk("R4 no store", sd_cnt, 0); chk("R4 no drive", bc, 0); chk("R4 idle", rd_inh, 0);

    // R3 / R6: sweep request widths with dirty array
    for (int w = 1; w <= MINP + 3; w++) begin
      write1(); clr(); ext_pulse(w); run(60);
      chk("R3 width accept", sd_cnt, (w >= MINP) ? 1 : 0);
      chk("R6 drive cycles", bc, (w >= MINP) ? STORE : 0);
    end
    // leave array clean for following tests
    ext_pulse(MINP + 2); run(60);

    // R5 / R7 / R10: held request line
    write1(); clr(); ext_pull = 1'b1; n = 0;
    for (int i = 0; i < 40 && !busy; i++) begin
      tick();
      if (wr_inh && !rd_inh) n++;
    end
    chk("R5 grace window", n, GRACE + 1);
    chk("R6 rd_inh in store", rd_inh, 1);
    run(3); wr_done = 1'b1; tick(); wr_done = 1'b0;   // R10: write report mid-store
    run(STORE + 10);
    chk("R6 store done once", sd_cnt, 1);
    chk("R7 held inhibited", rd_inh, 1);
    ext_pull = 1'b0; n = 0;
    for (int i = 1; i <= 40; i++) begin tick(); if (!rd_inh) begin n = i; break; end end
    chk("R7 release latency", n, SYNC + 1 + RESTORE);
    clr(); ext_pulse(6); run(60);
    chk("R10 mid-store write ignored", sd_cnt, 0);

    // R8: supply loss, dirty
    write1(); clr(); pwr_ok = 1'b0; run(60);
    chk("R8 pf store", sd_cnt, 1); chk("R8 pf drive", bc, GRACE + STORE);
    chk("R8 power-low", rd_inh, 1); chk("R8 no recall yet", rc_cnt, 0);
    power_up(); chk("R2 recall after store", rc_cnt, 1);

    // R8: supply loss, clean
    clr(); pwr_ok = 1'b0; run(40);
    chk("R8 clean no drive", bc, 0); chk("R8 clean no store", sd_cnt, 0);
    chk("R8 clean power-low", wr_inh, 1);
    power_up(); chk("R8 clean recall", rc_cnt, 1);

    // R9: line overpowered
    write1(); hold_high = 1'b1; clr(); pwr_ok = 1'b0; run(60);
    chk("R9 drive only grace", bc, GRACE); chk("R9 no store", sd_cnt, 0);
    chk("R9 power-low", rd_inh, 1);
    hold_high = 1'b0; power_up();
    chk("R9 recall", rc_cnt, 1); chk("R9 idle", rd_inh, 0);

    // R11: coincident sources merge
    write1(); clr(); ext_pull = 1'b1; pwr_ok = 1'b0; run(8); ext_pull = 1'b0; run(60);
    chk("R11 merged store", sd_cnt, 1);
    power_up();

    // R11: request during store ignored
    write1(); clr(); ext_pulse(5);
    for (int i = 0; i < 40 && !busy; i++) tick();
    ext_pulse(5); run(80);
    chk("R11 overlap store", sd_cnt, 1); chk("R11 idle", rd_inh, 0);

    // R12: supply dip during recall
    clr(); pwr_ok = 1'b0; run(5); pwr_ok = 1'b1; run(4); pwr_ok = 1'b0; run(5);
    chk("R12 no recall done", rc_cnt, 0); chk("R12 inhibited", rd_inh, 1);
    power_up(); chk("R12 recall rerun", rc_cnt, 1); chk("R12 idle", rd_inh, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule